// File: doc/BRIEF.md
# Cipher Mode Control Register with Context Handshake

This block is the 32-bit mode and status register of a block-cipher accelerator. The host reaches it over a plain register bus with an address, a write strobe, write data, a read strobe and combinational read data. It stores the mode fields that steer the engine. These include the CCM tag-length code and the CCM length-field code. It also turns those two codes into byte counts for the datapath.

Two flags carry the handshake between host and engine. The context-free flag says the host may load a new context. The result-waiting flag says that a tag or IV is held for collection. When the engine finishes an operation with the save option on, the context-free flag drops and the result-waiting flag rises. The host then either reads the four-word tag window or writes the release bit. Either action hands the register back for the next context.

Top module: `crypto_mode_reg`

## Requirements
- R1: After reset the control word reads 0x8000_0000: bit 31 (context-free) is 1 and every other bit is 0.
- R2: A write to the control address while context-free is 1 stores the mode bits of the write data. These are bit 29 (save), bits 24:22 (M code), bits 21:19 (L code), bit 18, bit 15, bits 8:7, bit 6, bit 5, bits 4:3 and bit 2. All other bits read 0.
- R3: Bit 31 (context-free) and bit 30 (result-waiting) are never 1 together.
- R4: An op_done_i pulse while context-free is 1 and save is 1 clears context-free and sets result-waiting. With save at 0, the pulse leaves both flags unchanged.
- R5: While result-waiting is 1, a control write with bit 29 set clears result-waiting and sets context-free. No mode bit changes in that access.
- R6: While result-waiting is 1, the fourth read of a tag window address clears result-waiting and sets context-free. The count restarts at 0 each time result-waiting is set. Window reads while result-waiting is 0, and reads of other addresses, are not counted.
- R7: A control write while context-free is 0 leaves all mode bits unchanged.
- R8: Bits 28:25 always read 0, even after a write of all ones.
- R9: tag_bytes_o equals 2*(M+1) and len_bytes_o equals L+1.
- R10: A read of window word k (address TAG_BASE+k) returns bits 32k+31:32k of tag_i. Any address outside the control word and the window reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register bus address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational on addr_i |
| op_done_i | input | 1 | One-cycle pulse from the engine at the end of an operation |
| tag_i | input | 128 | Tag/IV result from the engine |
| ctx_free_o | output | 1 | Host may load a new context |
| res_wait_o | output | 1 | Tag/IV waiting for collection |
| mode_o | output | 32 | Stored mode bits, with both flags masked to 0 |
| tag_bytes_o | output | 5 | Valid tag length in bytes |
| len_bytes_o | output | 4 | CCM length-field width in bytes |

## Verification
The bench builds the block with its default parameters: an 8-bit address, the control word at 0x00 and a four-word tag window at 0x10. With these values the window counter wraps after exactly four reads, so the count boundary is reached on every collection. Reads at 0x14, just past the window, show that neighbouring addresses are not counted. The bench steps the M and L codes across their extremes, which covers the shortest and longest tag lengths. It also issues release writes carrying unrelated mode bits, and writes at times when the context is busy.

// File: rtl/crypto_mode_pkg.sv
package crypto_mode_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BIT_FREE  = 31;
  localparam int unsigned BIT_WAIT  = 30;
  localparam int unsigned BIT_SAVE  = 29;
  localparam int unsigned M_LSB     = 22;
  localparam int unsigned L_LSB     = 19;
  localparam int unsigned CODE_W    = 3;
  localparam logic [WORD_W-1:0] MODE_MASK = 32'h21FC_81FC;
endpackage

// File: rtl/cm_field_store.sv
module cm_field_store
  import crypto_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] mode_o,
  output logic [4:0]        tag_bytes_o,
  output logic [3:0]        len_bytes_o
);
  logic [WORD_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (wr_en_i) mode_q <= wdata_i & MODE_MASK;
  end

  assign mode_o = mode_q;

  logic [CODE_W-1:0] m_code, l_code;
  assign m_code      = mode_q[M_LSB +: CODE_W];
  assign l_code      = mode_q[L_LSB +: CODE_W];
  assign tag_bytes_o = {1'b0, m_code, 1'b0} + 5'd2;
  assign len_bytes_o = {1'b0, l_code} + 4'd1;

  // R7: no write strobe, no change
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mode_q));
  // R8: reserved bits stay clear
  a_r8_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q[28:25] == 4'd0);
endmodule

// File: rtl/cm_handshake.sv
module cm_handshake
  import crypto_mode_pkg::*;
#(
  parameter int unsigned TAG_WORDS = 4,
  localparam int unsigned CNT_W = (TAG_WORDS > 1) ? $clog2(TAG_WORDS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic op_done_i,
  input  logic save_i,
  input  logic release_wr_i,
  input  logic tag_rd_i,
  output logic ctx_free_o,
  output logic res_wait_o
);
  logic             free_q, wait_q;
  logic [CNT_W-1:0] cnt_q;
  logic             res_set, last_rd, hand_back;

  assign res_set   = op_done_i & free_q & save_i;
  assign last_rd   = tag_rd_i & wait_q & (cnt_q == CNT_W'(TAG_WORDS - 1));
  assign hand_back = wait_q & (release_wr_i | last_rd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= 1'b1;
      wait_q <= 1'b0;
      cnt_q  <= '0;
    end else if (res_set) begin
      free_q <= 1'b0;
      wait_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hand_back) begin
      free_q <= 1'b1;
      wait_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tag_rd_i && wait_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign ctx_free_o = free_q;
  assign res_wait_o = wait_q;

  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(free_q && wait_q));
  a_r4_save_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && free_q && save_i) |=> (wait_q && !free_q));
  a_r4_plain_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && free_q && !save_i) |=> free_q);
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q && release_wr_i) |=> (free_q && !wait_q));
  a_r6_idle_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_q && !op_done_i) |=> !wait_q);
endmodule

// File: rtl/crypto_mode_reg.sv
module crypto_mode_reg
  import crypto_mode_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] TAG_BASE  = 8'h10,
  parameter int unsigned TAG_WORDS = 4,
  localparam int unsigned IDX_W = (TAG_WORDS > 1) ? $clog2(TAG_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              re_i,
  output logic [31:0]       rdata_o,
  input  logic              op_done_i,
  input  logic [32*TAG_WORDS-1:0] tag_i,
  output logic              ctx_free_o,
  output logic              res_wait_o,
  output logic [31:0]       mode_o,
  output logic [4:0]        tag_bytes_o,
  output logic [3:0]        len_bytes_o
);
  logic ctl_hit, tag_hit, ctl_wr;
  logic [IDX_W-1:0] tag_idx;
  logic [ADDR_W-1:0] tag_off;

  assign ctl_hit = (addr_i == CTRL_ADDR);
  assign tag_off = addr_i - TAG_BASE;
  assign tag_hit = (addr_i >= TAG_BASE) && (tag_off < ADDR_W'(TAG_WORDS));
  assign tag_idx = tag_off[IDX_W-1:0];
  assign ctl_wr  = we_i & ctl_hit;

  cm_handshake #(.TAG_WORDS(TAG_WORDS)) u_hs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_done_i    (op_done_i),
    .save_i       (mode_o[BIT_SAVE]),
    .release_wr_i (ctl_wr & wdata_i[BIT_SAVE]),
    .tag_rd_i     (re_i & tag_hit),
    .ctx_free_o   (ctx_free_o),
    .res_wait_o   (res_wait_o)
  );

  cm_field_store u_fields (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (ctl_wr & ctx_free_o),
    .wdata_i     (wdata_i),
    .mode_o      (mode_o),
    .tag_bytes_o (tag_bytes_o),
    .len_bytes_o (len_bytes_o)
  );

  always_comb begin
    rdata_o = '0;
    if (ctl_hit) begin
      rdata_o = mode_o;
      rdata_o[BIT_FREE] = ctx_free_o;
      rdata_o[BIT_WAIT] = res_wait_o;
    end else if (tag_hit) begin
      rdata_o = tag_i[32*tag_idx +: 32];
    end
  end

  // R5: release access leaves mode untouched
  a_r5_mode_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_wait_o && ctl_wr) |=> $stable(mode_o));
endmodule

// File: tb/tb_crypto_mode_reg.sv
module tb_crypto_mode_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h21FC_81FC;

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0;
  logic we = 0, re = 0, op_done = 0;
  logic [31:0] wdata = 0, rdata, mode;
  logic [127:0] tag = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
  logic ctx_free, res_wait;
  logic [4:0] tag_bytes;
  logic [3:0] len_bytes;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crypto_mode_reg dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .op_done_i(op_done), .tag_i(tag),
    .ctx_free_o(ctx_free), .res_wait_o(res_wait), .mode_o(mode),
    .tag_bytes_o(tag_bytes), .len_bytes_o(len_bytes));

  // reference model
  bit m_free, m_wait;
  logic [31:0] m_mode;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_free <= 1; m_wait <= 0; m_mode <= 0; m_cnt <= 0;
    end else begin
      bit wr, trd;
      wr  = we && addr == 8'h00;
      trd = re && addr >= 8'h10 && addr <= 8'h13;
      if (op_done && m_free && m_mode[29]) begin
        m_free <= 0; m_wait <= 1; m_cnt <= 0;
      end else if (m_wait && ((wr && wdata[29]) || (trd && m_cnt == 3))) begin
        m_free <= 1; m_wait <= 0; m_cnt <= 0;
      end else if (trd && m_wait) m_cnt <= m_cnt + 1;
      if (wr && m_free) m_mode <= wdata & MASK;
    end
  end

  function automatic logic [31:0] exp_rdata();
    if (addr == 8'h00) return {m_free, m_wait, m_mode[29:0]};
    if (addr >= 8'h10 && addr <= 8'h13) return tag[32*(addr-8'h10) +: 32];
    return 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R3/R4/R5/R6 ctx_free", {31'd0, ctx_free}, {31'd0, m_free});
    chk("R3/R4/R5/R6 res_wait", {31'd0, res_wait}, {31'd0, m_wait});
    chk("R2/R7/R8 mode", mode, m_mode);
    chk("R9 tag_bytes", {27'd0, tag_bytes}, {27'd0, 5'(2 * (m_mode[24:22] + 1))});
    chk("R9 len_bytes", {28'd0, len_bytes}, {28'd0, 4'(m_mode[21:19] + 1)});
    chk("R10 rdata", rdata, exp_rdata());
  end

  task automatic idle();
    we = 0; re = 0; op_done = 0;
  endtask
  task automatic wr(input logic [31:0] d);
    @(negedge clk); #1; idle(); addr = 8'h00; we = 1; wdata = d;
    @(negedge clk); #1; idle();
  endtask
  task automatic rd(input logic [7:0] a);
    @(negedge clk); #1; idle(); addr = a; re = 1;
    @(negedge clk); #1; idle();
  endtask
  task automatic done_pulse();
    @(negedge clk); #1; idle(); op_done = 1;
    @(negedge clk); #1; idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset value
    addr = 8'h00;
    chk("R1 reset word", rdata, 32'h8000_0000);
    // R2/R9: field writes at M/L extremes
    wr(32'h0000_0004);
    wr({3'b0, 1'b0, 4'h0, 3'd7, 3'd0, 19'h0});
    #1; chk("R9 max M", {27'd0, tag_bytes}, 32'd16);
    wr({3'b0, 1'b0, 4'h0, 3'd0, 3'd7, 19'h0});
    #1; chk("R9 min M / max L", {27'd0, tag_bytes, len_bytes}, {23'd0, 5'd2, 4'd8});
    // R8: all ones
    wr(32'hFFFF_FFFF);
    addr = 8'h00; #1;
    chk("R8 reserved read", {28'd0, rdata[28:25]}, 32'd0);
    // R4: done with save clear
    wr(32'h0000_81FC);
    done_pulse();
    #1; chk("R4 no save keeps free", {31'd0, ctx_free}, 32'd1);
    // window reads with no result waiting are not counted (R6)
    rd(8'h10); rd(8'h11); rd(8'h12);
    // R4: done with save set
    wr(32'h2058_0000);
    done_pulse();
    #1; chk("R4 save sets wait", {30'd0, ctx_free, res_wait}, 32'd1);
    // R7: busy write ignored
    wr(32'h0000_0008);
    // R6: three reads plus outside reads, then fourth
    rd(8'h10); rd(8'h14); rd(8'h11); rd(8'h00); rd(8'h13);
    #1; chk("R6 three reads hold", {31'd0, res_wait}, 32'd1);
    rd(8'h12);
    #1; chk("R6 fourth read frees", {30'd0, ctx_free, res_wait}, 32'd2);
    // R5: release write carrying other bits
    done_pulse();
    wr(32'h0000_0004);
    wr(32'h21C0_0000);
    #1; chk("R5 release frees", {30'd0, ctx_free, res_wait}, 32'd2);
    chk("R5 mode kept", mode, 32'h2058_0000);
    // R6: count restarts after a fresh result
    done_pulse();
    rd(8'h10); rd(8'h11);
    wr(32'h2000_0000);
    done_pulse();
    rd(8'h10); rd(8'h11); rd(8'h12);
    #1; chk("R6 count restarted", {31'd0, res_wait}, 32'd1);
    rd(8'h13);
    // R10: outside address
    @(negedge clk); #1; addr = 8'h20; #1;
    chk("R10 unmapped", rdata, 32'd0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule